// File: doc/BRIEF.md
# MFM Gap-Interval Read Decoder

This block turns the raw read-data line of a floppy drive into decoded bytes. The line idles high and pulls low briefly for every flux transition. The block synchronises the line to the system clock and marks each high-to-low transition. It measures the time between successive transitions in clock cycles and rounds that time to 1.0, 1.5 or 2.0 nominal bit-cell units. The length of one unit in cycles comes from a run-time input, so the same logic serves different data rates.

A small table turns each rounded gap, together with the last decoded bit, into one or two new bits. Before any bits are assembled, the decoder has to find the alignment mark. That mark is a run of four gaps that normal data never produces: 2.0, 1.5, 2.0, 1.5. Once the mark is found, decoded bits are shifted into a byte register. A strobe fires for each completed byte. A separate strobe reports every alignment mark, and a third strobe reports any gap outside the accepted range. Clock recovery, CRC checking and sector parsing are handled elsewhere.

Top module: `mfm_gap_reader`

## Requirements
- R1: Each high-to-low transition of `rd_n` counts as exactly one flux pulse, whatever the width of the low level. Intervals are measured from one falling edge to the next.
- R2: An interval of D cycles with unit length U is classified by comparing 4·D with multiples of U. 4·D < 3·U is an error. 3·U ≤ 4·D < 5·U gives 1.0. 5·U ≤ 4·D < 7·U gives 1.5. 7·U ≤ 4·D ≤ 10·U gives 2.0. 4·D > 10·U is an error.
- R3: When the last decoded bit is 0, a 1.0 gap emits one 0 bit and a 1.5 gap emits one 1 bit.
- R4: When the last decoded bit is 1, a 1.0 gap emits one 1 bit and a 1.5 gap emits the two bits 0 then 0.
- R5: A 2.0 gap emits the bits 0 then 1, whatever the last bit was.
- R6: Four valid gaps in a row of 2.0, 1.5, 2.0, 1.5, with no alignment mark or error among them, form an alignment mark. On that mark `sync_found` pulses for one cycle with `byte_data` = 0xA1. The last decoded bit becomes 1, the bit counter returns to 0, and the gap history is cleared.
- R7: No `byte_valid` occurs until an alignment mark has been seen. This holds after reset and after any error.
- R8: An error gap pulses `gap_err` for one cycle, drops alignment and clears the gap history.
- R9: Bits enter the byte MSB first. `byte_valid` pulses with the byte after every eighth bit since alignment. When a gap emits two bits across a byte boundary, the second bit starts the next byte.
- R10: The `sync_found`, `byte_valid` and `gap_err` strobes rise on the fourth rising clock edge after the first edge that samples the closing falling edge of `rd_n` low.
- R11: `unit_len` is read at run time. The first pulse after reset only starts a measurement and reports neither a gap nor an error.
- R12: While and just after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Raw read-data line, active low, asynchronous |
| unit_len | input | UNIT_W | Nominal 1.0 gap length in clock cycles |
| byte_valid | output | 1 | One-cycle strobe: `byte_data` holds a decoded byte |
| byte_data | output | 8 | Last decoded byte, or 0xA1 on an alignment mark |
| sync_found | output | 1 | One-cycle strobe: alignment mark detected |
| gap_err | output | 1 | One-cycle strobe: gap out of range |

## Verification
Every result of this block appears a fixed four rising edges after the edge that first samples the closing falling edge of `rd_n`. That delay covers two synchroniser stages, the registered edge strobe, the registered gap class and the registered output stage. The bench drives `rd_n` on falling clock edges and notes the cycle count of each fall. A monitor samples the outputs on falling edges, so every strobe is seen half a cycle after it rises. Latency checks compare the recorded strobe cycle with the fall cycle plus five. The other checks run only after the interval-generating task has waited at least eleven cycles past the last fall, so every strobe due from that fall has already arrived.

// File: rtl/mfm_pkg.sv
package mfm_pkg;

   // quantised gap classes
   typedef enum logic [1:0] {
      GQ_BAD = 2'd0,
      GQ_1P0 = 2'd1,
      GQ_1P5 = 2'd2,
      GQ_2P0 = 2'd3
   } gap_q_e;

   localparam int BYTE_W   = 8;
   localparam int BCNT_W   = $clog2(BYTE_W);
   localparam int SYNC_LEN = 4;

   // alignment run, oldest gap in the top slot, newest in [1:0]
   localparam logic [2*SYNC_LEN-1:0] SYNC_PAT = {GQ_2P0, GQ_1P5, GQ_2P0, GQ_1P5};
   localparam logic [BYTE_W-1:0]     SYNC_BYTE = 8'hA1;

   // n: number of emitted bits, b[1] first bit, b[0] second bit
   typedef struct packed {
      logic [1:0] n;
      logic [1:0] b;
   } gap_bits_t;

   function automatic gap_bits_t gap_to_bits(gap_q_e q, logic prev);
      gap_bits_t r;
      r = '0;
      case (q)
         GQ_1P0: begin r.n = 2'd1; r.b = {prev, 1'b0}; end
         GQ_1P5: begin
            if (prev) begin r.n = 2'd2; r.b = 2'b00; end
            else      begin r.n = 2'd1; r.b = 2'b10; end
         end
         GQ_2P0: begin r.n = 2'd2; r.b = 2'b01; end
         default: r = '0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/mfm_flux_edge.sv
module mfm_flux_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_n,
   output logic flux_edge
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   fall;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("mfm_flux_edge: SYNC_STAGES must be at least 2");
   end

   // line idles high, so reset to ones to avoid a false edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         last_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], rd_n};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign fall = last_q & ~sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flux_edge <= 1'b0;
      else        flux_edge <= fall;
   end

endmodule

// File: rtl/mfm_gap_quant.sv
module mfm_gap_quant
   import mfm_pkg::*;
#(
   parameter int CNT_W  = 12,
   parameter int UNIT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flux_edge,
   input  logic [UNIT_W-1:0] unit_len,
   output logic              gap_vld,
   output gap_q_e            gap_q
);

   localparam int MW = CNT_W + 4;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   logic [MW-1:0]    d4, u1, th_lo, th_15, th_20, th_hi;
   gap_q_e           cls;

   if (CNT_W < UNIT_W + 4) begin : g_bad_cnt
      $error("mfm_gap_quant: CNT_W must be at least UNIT_W+4");
   end

   // thresholds at 0.75, 1.25, 1.75 and 2.5 units, built from shifts
   assign d4    = MW'(cnt_q) << 2;
   assign u1    = MW'(unit_len);
   assign th_lo = (u1 << 1) + u1;
   assign th_15 = (u1 << 2) + u1;
   assign th_20 = (u1 << 3) - u1;
   assign th_hi = (u1 << 3) + (u1 << 1);

   always_comb begin
      if (d4 < th_lo)       cls = GQ_BAD;
      else if (d4 < th_15)  cls = GQ_1P0;
      else if (d4 < th_20)  cls = GQ_1P5;
      else if (d4 <= th_hi) cls = GQ_2P0;
      else                  cls = GQ_BAD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         gap_vld <= 1'b0;
         gap_q   <= GQ_BAD;
      end else if (flux_edge) begin
         cnt_q   <= CNT_W'(1);
         armed_q <= 1'b1;
         gap_vld <= armed_q;
         gap_q   <= cls;
      end else begin
         gap_vld <= 1'b0;
         if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/mfm_bit_engine.sv
module mfm_bit_engine
   import mfm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gap_vld,
   input  gap_q_e            gap_q,
   output logic              locked,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] byte_data,
   output logic              sync_found,
   output logic              gap_err
);

   localparam int HIST = SYNC_LEN - 1;

   gap_q_e              hist_q [HIST];
   logic [HIST-1:0]     hit;
   logic                is_sync;
   logic                prev_q;
   logic [BYTE_W-1:0]   sr_q, sr_n, byte_n;
   logic [BCNT_W-1:0]   cnt_q, cnt_n;
   logic                emit, last_bit;
   gap_bits_t           dec;

   // compare stored gaps against the alignment run
   for (genvar k = 0; k < HIST; k++) begin : g_hist
      assign hit[k] = (hist_q[k] == gap_q_e'(SYNC_PAT[2*(k+1) +: 2]));
   end

   assign is_sync = (gap_q == gap_q_e'(SYNC_PAT[1:0])) && (&hit);
   assign dec     = gap_to_bits(gap_q, prev_q);
   assign last_bit = (dec.n == 2'd2) ? dec.b[0] : dec.b[1];

   // shift up to two bits, noting a completed byte between them
   always_comb begin
      sr_n   = sr_q;
      cnt_n  = cnt_q;
      emit   = 1'b0;
      byte_n = sr_q;
      for (int i = 0; i < 2; i++) begin
         if (i < int'(dec.n)) begin
            sr_n = {sr_n[BYTE_W-2:0], dec.b[1-i]};
            if (cnt_n == BCNT_W'(BYTE_W-1)) begin
               emit   = 1'b1;
               byte_n = sr_n;
            end
            cnt_n = cnt_n + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked     <= 1'b0;
         prev_q     <= 1'b0;
         sr_q       <= '0;
         cnt_q      <= '0;
         byte_valid <= 1'b0;
         byte_data  <= '0;
         sync_found <= 1'b0;
         gap_err    <= 1'b0;
         for (int k = 0; k < HIST; k++) hist_q[k] <= GQ_BAD;
      end else begin
         byte_valid <= 1'b0;
         sync_found <= 1'b0;
         gap_err    <= 1'b0;
         if (gap_vld) begin
            if (gap_q == GQ_BAD) begin
               gap_err <= 1'b1;
               locked  <= 1'b0;
               for (int k = 0; k < HIST; k++) hist_q[k] <= GQ_BAD;
            end else if (is_sync) begin
               sync_found <= 1'b1;
               locked     <= 1'b1;
               prev_q     <= 1'b1;
               cnt_q      <= '0;
               byte_data  <= SYNC_BYTE;
               for (int k = 0; k < HIST; k++) hist_q[k] <= GQ_BAD;
            end else begin
               hist_q[0] <= gap_q;
               for (int k = 1; k < HIST; k++) hist_q[k] <= hist_q[k-1];
               if (locked) begin
                  sr_q   <= sr_n;
                  cnt_q  <= cnt_n;
                  prev_q <= last_bit;
                  if (emit) begin
                     byte_valid <= 1'b1;
                     byte_data  <= byte_n;
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/mfm_gap_reader.sv
module mfm_gap_reader
   import mfm_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int UNIT_W      = 8,
   parameter int CNT_W       = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_n,
   input  logic [UNIT_W-1:0] unit_len,
   output logic              byte_valid,
   output logic [7:0]        byte_data,
   output logic              sync_found,
   output logic              gap_err
);

   logic   flux_edge;
   logic   gap_vld;
   gap_q_e gap_q;
   logic   locked;

   mfm_flux_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_n      (rd_n),
      .flux_edge (flux_edge)
   );

   mfm_gap_quant #(.CNT_W(CNT_W), .UNIT_W(UNIT_W)) u_quant (
      .clk       (clk),
      .rst_n     (rst_n),
      .flux_edge (flux_edge),
      .unit_len  (unit_len),
      .gap_vld   (gap_vld),
      .gap_q     (gap_q)
   );

   mfm_bit_engine u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .gap_vld    (gap_vld),
      .gap_q      (gap_q),
      .locked     (locked),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .sync_found (sync_found),
      .gap_err    (gap_err)
   );

endmodule

// File: rtl/mfm_gap_reader_chk.sv
module mfm_gap_reader_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       flux_edge,
   input logic       gap_vld,
   input logic       locked,
   input logic       byte_valid,
   input logic [7:0] byte_data,
   input logic       sync_found,
   input logic       gap_err
);

   // R1: two falling edges can never be one cycle apart
   p_single_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
      flux_edge |=> !flux_edge);

   // R6: an alignment mark always presents 0xA1
   p_sync_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_found |-> (byte_data == 8'hA1));

   // R6: mark and byte strobes never coincide
   p_sync_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_found |-> !byte_valid);

   // R8: an error strobe stands alone
   p_err_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gap_err |-> (!byte_valid && !sync_found));

   // R7: a byte needs alignment held before it
   p_byte_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> $past(locked));

   // R8: alignment is gone after an error
   p_err_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gap_err |-> !locked);

   // R10: each stage follows the previous one by exactly one cycle
   p_gap_after_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
      gap_vld |-> $past(flux_edge));

   p_out_after_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid || sync_found || gap_err) |-> $past(gap_vld));

   // strobes are mutually exclusive
   p_onehot_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({byte_valid, sync_found, gap_err}));

endmodule

bind mfm_gap_reader mfm_gap_reader_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flux_edge  (flux_edge),
   .gap_vld    (gap_vld),
   .locked     (locked),
   .byte_valid (byte_valid),
   .byte_data  (byte_data),
   .sync_found (sync_found),
   .gap_err    (gap_err)
);

// File: tb/sim_mfm_gap_reader.sv
`timescale 1ns/1ps
module sim_mfm_gap_reader;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_n = 1'b1;
   logic [7:0] unit_len = 8'd16;
   logic       byte_valid, sync_found, gap_err;
   logic [7:0] byte_data;

   mfm_gap_reader u0 (
      .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .unit_len(unit_len),
      .byte_valid(byte_valid), .byte_data(byte_data),
      .sync_found(sync_found), .gap_err(gap_err)
   );

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // monitor
   logic [7:0] got[$];
   int n_sync = 0, n_err = 0, sync_cyc = 0, byte_cyc = 0;
   logic [7:0] sync_dat = 8'h00;
   always @(negedge clk) begin
      if (rst_n) begin
         if (byte_valid) begin got.push_back(byte_data); byte_cyc = cyc; end
         if (sync_found) begin n_sync++; sync_cyc = cyc; sync_dat = byte_data; end
         if (gap_err) n_err++;
      end
   end

   int n_tests = 0, n_fail = 0;
   int fall_cyc = 0;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
      end
   endtask

   // reference bit model from the decode table
   bit ebits[$];
   bit mprev;
   task automatic model(int h);
      case (h)
         2: ebits.push_back(mprev);
         3: if (!mprev) begin ebits.push_back(1'b1); mprev = 1'b1; end
            else begin ebits.push_back(1'b0); ebits.push_back(1'b0); mprev = 1'b0; end
         4: begin ebits.push_back(1'b0); ebits.push_back(1'b1); mprev = 1'b1; end
         default: ;
      endcase
   endtask

   function automatic int classify(int d, int u);
      if (4*d < 3*u) return 0;
      if (4*d < 5*u) return 2;
      if (4*d < 7*u) return 3;
      if (4*d <= 10*u) return 4;
      return 0;
   endfunction

   function automatic logic [7:0] exp_byte(int k);
      logic [7:0] e = 8'h00;
      for (int j = 0; j < 8; j++) e = {e[6:0], ebits[8*k+j]};
      return e;
   endfunction

   // called at a falling clock edge; next fall lands d cycles later
   task automatic pulse(int d, int w);
      rd_n = 1'b0;
      fall_cyc = cyc;
      repeat (w) @(negedge clk);
      rd_n = 1'b1;
      repeat (d - w) @(negedge clk);
   endtask

   task automatic idle();
      rd_n = 1'b1;
      repeat (100) @(negedge clk);
   endtask

   task automatic send_sync(int u);
      pulse(2*u, 4); pulse(3*u/2, 4); pulse(2*u, 4); pulse(3*u/2, 4);
   endtask

   int seq[$];

   task automatic run_seq(int u, bit vary, string req);
      int b0, s0, nb;
      idle();
      b0 = got.size(); s0 = n_sync;
      ebits.delete(); mprev = 1'b1;
      send_sync(u);
      foreach (seq[i]) begin
         pulse(seq[i]*u/2, vary ? 2 + (i % 9) : 4);
         model(seq[i]);
      end
      pulse(2*u, 4);
      nb = ebits.size() / 8;
      chk(n_sync - s0 == 1, req, "mark count", n_sync - s0, 1);
      chk(got.size() - b0 == nb, req, "byte count", got.size() - b0, nb);
      for (int k = 0; k < nb; k++)
         if (b0 + k < got.size())
            chk(got[b0+k] == exp_byte(k), req, $sformatf("byte %0d", k), got[b0+k], exp_byte(k));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      chk(!byte_valid && !sync_found && !gap_err, "R12", "strobes in reset",
          {byte_valid, sync_found, gap_err}, 0);
      chk(byte_data == 8'h00, "R12", "data in reset", byte_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(byte_data == 8'h00 && !byte_valid, "R12", "after release", byte_data, 0);
   endtask

   task automatic t_presync();
      int b0, s0, e0;
      idle();
      b0 = got.size(); s0 = n_sync; e0 = n_err;
      foreach (seq[i]) pulse(seq[i]*8, 4);
      pulse(32, 4);
      chk(got.size() == b0, "R7", "bytes before mark", got.size() - b0, 0);
      chk(n_sync == s0, "R7", "marks in plain data", n_sync - s0, 0);
      chk(n_err == e0, "R11", "first pulse only arms", n_err - e0, 0);
   endtask

   task automatic t_sync();
      int b0, s0, fc;
      idle();
      b0 = got.size(); s0 = n_sync;
      send_sync(16);
      chk(n_sync == s0, "R6", "three gaps are no mark", n_sync - s0, 0);
      pulse(32, 4);
      fc = fall_cyc;
      chk(n_sync - s0 == 1, "R6", "mark seen", n_sync - s0, 1);
      chk(sync_dat == 8'hA1, "R6", "mark byte", sync_dat, 8'hA1);
      chk(sync_cyc == fc + 5, "R10", "mark latency", sync_cyc - fc, 5);
      chk(got.size() == b0, "R6", "no byte on mark", got.size() - b0, 0);
   endtask

   task automatic t_resync();
      int b0, s0, fc;
      idle();
      send_sync(16);
      pulse(16, 4);
      b0 = got.size(); s0 = n_sync;
      pulse(32, 4); pulse(24, 4); pulse(32, 4); pulse(24, 4);
      pulse(16, 4);
      repeat (7) pulse(16, 4);
      pulse(32, 4);
      fc = fall_cyc;
      chk(n_sync - s0 == 1, "R6", "second mark", n_sync - s0, 1);
      chk(got.size() - b0 == 1, "R9", "counter realigned", got.size() - b0, 1);
      if (got.size() > b0)
         chk(got[b0] == 8'hFF, "R4", "ones after mark", got[b0], 8'hFF);
      chk(byte_cyc == fc + 5, "R10", "byte latency", byte_cyc - fc, 5);
   endtask

   task automatic t_bound(int d);
      int b0, e0, c;
      idle();
      send_sync(16);
      pulse(d, 4);
      b0 = got.size(); e0 = n_err;
      repeat (8) pulse(16, 4);
      pulse(32, 4);
      c = classify(d, 16);
      if (c == 0) begin
         chk(n_err - e0 == 1, "R2", $sformatf("error at D=%0d", d), n_err - e0, 1);
         chk(got.size() == b0, "R8", $sformatf("no bytes after D=%0d", d), got.size() - b0, 0);
      end else begin
         ebits.delete(); mprev = 1'b1;
         model(c);
         repeat (8) model(2);
         chk(n_err == e0, "R2", $sformatf("no error at D=%0d", d), n_err - e0, 0);
         chk(got.size() - b0 == 1, "R2", $sformatf("one byte at D=%0d", d), got.size() - b0, 1);
         if (got.size() > b0)
            chk(got[b0] == exp_byte(0), "R2", $sformatf("class at D=%0d", d), got[b0], exp_byte(0));
      end
   endtask

   task automatic t_error(int bad);
      int b0, e0;
      idle();
      send_sync(16);
      pulse(16, 4);
      b0 = got.size(); e0 = n_err;
      pulse(bad, 3);
      repeat (16) pulse(16, 4);
      pulse(32, 4);
      chk(n_err - e0 == 1, "R8", $sformatf("error strobe for %0d", bad), n_err - e0, 1);
      chk(got.size() == b0, "R8", $sformatf("alignment lost after %0d", bad), got.size() - b0, 0);
   endtask

   initial begin
      seq = '{2,2,3,4,2,3,3,4,2,2,2,4,3,2,4,4,3,3,2,4,2,2,3,2,4,2,2,3,2,2,4,3,3,2,2,2};
      t_reset();
      t_presync();
      t_sync();
      run_seq(16, 1'b0, "R3 R4 R5 R9");
      run_seq(16, 1'b1, "R1");
      t_resync();
      foreach (seq[i]) ;
      t_bound(11); t_bound(12); t_bound(19); t_bound(20);
      t_bound(27); t_bound(28); t_bound(40); t_bound(41);
      t_error(8);
      t_error(48);
      unit_len = 8'd24;
      run_seq(24, 1'b0, "R11");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule